// File: doc/BRIEF.md
# Run-Time Precision-Scalable Multiply-Accumulate

This block multiplies two 16-bit two's-complement operands and adds the product into an accumulator once per enabled clock cycle. The arithmetic precision is chosen at run time in two ways. First, a drop count asks for a number of low-order bits of every operand lane to be rounded away and zeroed before the multiply, so those bits stop toggling. Second, a lane mode splits the 16-bit operands into one, two or four independent signed lanes. Each lane has its own product and its own accumulator, which is a slice of the 48-bit accumulator register.

In use, a controller picks the narrowest lane mode that meets the precision a network layer needs. It issues a clear that also latches the new mode, then streams operand pairs with enable high. The packed accumulator value is read from the output port.

Top module: `scal_mac`

## Requirements
- R1: After reset `acc_o` is zero and `mode_o` reads 0, the single-lane mode.
- R2: Let k be `drop_i`, limited to W-1 for a lane of W bits. When k > 0, each lane operand is treated as signed. It is rounded half-up by adding 2^(k-1), and then its k least-significant bits are forced to zero before the multiply. When k is 0 the operand is used unchanged.
- R3: When the rounding step in R2 exceeds the largest positive W-bit value, the conditioned operand saturates to 2^(W-1) - 2^k.
- R4: In mode 0 (one lane), each enabled cycle adds the signed 16x16 product of `a_i` and `b_i` to the 48-bit accumulator. The result is visible on `acc_o` after that one clock edge.
- R5: In mode 1 (two lanes), lane i multiplies bits [8i+7:8i] of the two operands as signed bytes. It accumulates into `acc_o[24i+23:24i]`.
- R6: In mode 2 (four lanes), lane i multiplies bits [4i+3:4i] as signed nibbles. It accumulates into `acc_o[12i+11:12i]`.
- R7: Each lane accumulator wraps modulo 2^(48/N), where N is the lane count. No carry passes into a neighbouring lane.
- R8: A cycle with `clr_i` high zeroes every lane accumulator and latches `mode_i` as the active mode. Code 3 is taken as mode 0. Changes on `mode_i` without a clear have no effect on `mode_o` or on the arithmetic.
- R9: With `clr_i` and `en_i` both low, `acc_o` holds its value. `clr_i` takes priority over `en_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr_i | input | 1 | Synchronous clear of all lanes; latches `mode_i` |
| en_i | input | 1 | Accumulate this cycle |
| mode_i | input | 2 | Requested lane mode: 0 = 1x16, 1 = 2x8, 2 = 4x4 |
| drop_i | input | 4 | Number of LSBs per lane to round and zero |
| a_i | input | 16 | Operand A, packed lanes |
| b_i | input | 16 | Operand B, packed lanes |
| acc_o | output | 48 | Packed lane accumulators, lane 0 at the LSBs |
| mode_o | output | 2 | Active lane mode |

## Verification
The bench builds the block with its default widths: 16-bit operands and a 48-bit accumulator. With these widths all three lane modes are reachable, with 16-, 8- and 4-bit lanes. In the four-lane mode each lane accumulator is only 12 bits, so a lane can be made to wrap within 32 cycles, and the bench can confirm that the neighbouring lanes stay untouched. Because the drop count can reach 15, it exceeds every narrow lane width, which lets the bench check the clamping of the drop count and the saturated rounding results.

// File: rtl/scal_mac_pkg.sv
package scal_mac_pkg;

    typedef enum logic [1:0] {
        LANES_1 = 2'd0,
        LANES_2 = 2'd1,
        LANES_4 = 2'd2
    } lane_mode_e;

    // Reserved code 3 falls back to the single-lane mode.
    function automatic lane_mode_e decode_mode(input logic [1:0] code);
        case (code)
            2'd1:    return LANES_2;
            2'd2:    return LANES_4;
            default: return LANES_1;
        endcase
    endfunction

endpackage

// File: rtl/scal_mac_cond.sv
// Round-half-up and zero the low bits of one signed lane operand.
module scal_mac_cond #(
    parameter int W  = 16,
    parameter int KW = 4
) (
    input  logic [W-1:0]  x_i,
    input  logic [KW-1:0] drop_i,
    output logic [W-1:0]  y_o
);
    int                k;
    logic signed [W:0] sum;
    logic [W-1:0]      keep;

    always_comb begin
        k    = (int'(drop_i) > W - 1) ? W - 1 : int'(drop_i);
        keep = {W{1'b1}} << k;
        sum  = '0;
        if (k == 0) begin
            y_o = x_i;
        end else begin
            sum = $signed({x_i[W-1], x_i}) + $signed((W+1)'(1) << (k - 1));
            if (!sum[W] && sum[W-1]) begin
                y_o = {1'b0, {(W-1){1'b1}}} & keep;
            end else begin
                y_o = sum[W-1:0] & keep;
            end
        end
    end
endmodule

// File: rtl/scal_mac_mode.sv
// Next accumulator value for one lane configuration.
module scal_mac_mode #(
    parameter int DATA_W = 16,
    parameter int ACC_W  = 48,
    parameter int LANES  = 1,
    parameter int KW     = 4
) (
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic [KW-1:0]     drop_i,
    input  logic [ACC_W-1:0]  acc_i,
    output logic [ACC_W-1:0]  acc_o
);
    localparam int LW = DATA_W / LANES;
    localparam int AW = ACC_W / LANES;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [LW-1:0]          ca;
        logic [LW-1:0]          cb;
        logic signed [2*LW-1:0] prod;

        scal_mac_cond #(.W(LW), .KW(KW)) i_cond_a (
            .x_i(a_i[i*LW +: LW]), .drop_i(drop_i), .y_o(ca));
        scal_mac_cond #(.W(LW), .KW(KW)) i_cond_b (
            .x_i(b_i[i*LW +: LW]), .drop_i(drop_i), .y_o(cb));

        always_comb begin
            prod = $signed(ca) * $signed(cb);
            acc_o[i*AW +: AW] = acc_i[i*AW +: AW] + AW'(prod);
        end
    end
endmodule

// File: rtl/scal_mac.sv
module scal_mac
    import scal_mac_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ACC_W  = 48
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              en_i,
    input  logic [1:0]        mode_i,
    input  logic [3:0]        drop_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    output logic [ACC_W-1:0]  acc_o,
    output logic [1:0]        mode_o
);
    localparam int NUM_MODES = 3;
    localparam int KW        = 4;

    typedef struct packed {
        lane_mode_e       mode;
        logic [ACC_W-1:0] acc;
    } state_t;

    state_t           st_d, st_q;
    logic [ACC_W-1:0] nxt [NUM_MODES];

    for (genvar m = 0; m < NUM_MODES; m++) begin : g_mode
        scal_mac_mode #(
            .DATA_W(DATA_W), .ACC_W(ACC_W), .LANES(1 << m), .KW(KW)
        ) i_mode (
            .a_i(a_i), .b_i(b_i), .drop_i(drop_i),
            .acc_i(st_q.acc), .acc_o(nxt[m])
        );
    end

    always_comb begin
        st_d = st_q;
        if (clr_i) begin
            st_d.acc  = '0;
            st_d.mode = decode_mode(mode_i);
        end else if (en_i) begin
            case (st_q.mode)
                LANES_2: st_d.acc = nxt[1];
                LANES_4: st_d.acc = nxt[2];
                default: st_d.acc = nxt[0];
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{mode: LANES_1, acc: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign acc_o  = st_q.acc;
    assign mode_o = st_q.mode;

    assert_clear_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (acc_o == '0));

    assert_mode_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_i |=> $stable(mode_o));

    assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && !en_i) |=> $stable(acc_o));

    assert_zero_operand_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && en_i && a_i == '0) |=> $stable(acc_o));

endmodule

// File: tb/test_scal_mac.sv
module test_scal_mac;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clr_i = 1'b0;
    logic        en_i = 1'b0;
    logic [1:0]  mode_i = 2'd0;
    logic [3:0]  drop_i = 4'd0;
    logic [15:0] a_i = '0;
    logic [15:0] b_i = '0;
    logic [47:0] acc_o;
    logic [1:0]  mode_o;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    logic [47:0] m_acc = '0;
    int          m_mode = 0;

    scal_mac i_scal_mac (
        .clk(clk), .rst_n(rst_n), .clr_i(clr_i), .en_i(en_i),
        .mode_i(mode_i), .drop_i(drop_i), .a_i(a_i), .b_i(b_i),
        .acc_o(acc_o), .mode_o(mode_o)
    );

    always #4 clk = ~clk;

    function automatic longint condition(longint x, int w, int k);
        longint r, top;
        if (k > w - 1) k = w - 1;
        if (k == 0) return x;
        r = ((x + (64'sd1 << (k - 1))) >>> k) <<< k;
        top = (64'sd1 << (w - 1)) - (64'sd1 << k);
        if (r > top) r = top;
        return r;
    endfunction

    function automatic longint field(logic [15:0] v, int i, int w);
        longint f;
        f = longint'((v >> (i * w))) & ((64'sd1 << w) - 1);
        if (f >= (64'sd1 << (w - 1))) f = f - (64'sd1 << w);
        return f;
    endfunction

    task automatic model_step(logic [15:0] a, logic [15:0] b, int k);
        int n, w, aw;
        longint msk, sl, p;
        n  = 1 << m_mode;
        w  = 16 / n;
        aw = 48 / n;
        msk = (64'sd1 << aw) - 1;
        for (int i = 0; i < n; i++) begin
            p  = condition(field(a, i, w), w, k) * condition(field(b, i, w), w, k);
            sl = (longint'(m_acc) >> (i * aw)) & msk;
            sl = (sl + p) & msk;
            m_acc = 48'((longint'(m_acc) & ~(msk << (i * aw))) | (sl << (i * aw)));
        end
    endtask

    task automatic check48(string req, logic [47:0] act, logic [47:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: acc_o=%h expected %h", req, act, exp);
        end
    endtask

    task automatic check2(string req, logic [1:0] act, logic [1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: mode_o=%0d expected %0d", req, act, exp);
        end
    endtask

    // One clock: drive at negedge, sample at the following negedge.
    task automatic cycle(bit clr, bit en, logic [1:0] md, logic [3:0] k,
                         logic [15:0] a, logic [15:0] b);
        clr_i = clr; en_i = en; mode_i = md; drop_i = k; a_i = a; b_i = b;
        if (clr) begin
            m_acc = '0;
            m_mode = (md == 2'd3) ? 0 : int'(md);
        end else if (en) begin
            model_step(a, b, int'(k));
        end
        @(negedge clk);
        clr_i = 1'b0; en_i = 1'b0;
    endtask

    task automatic t_reset;
        check48("R1", acc_o, '0);
        check2("R1", mode_o, 2'd0);
    endtask

    task automatic t_full;
        cycle(1, 0, 2'd0, 4'd0, 0, 0);
        cycle(0, 1, 2'd0, 4'd0, 16'd300, 16'hFF9C);
        check48("R4", acc_o, m_acc);
        check48("R4", acc_o, 48'hFFFF_FFFF_8AD0);
        cycle(0, 1, 2'd0, 4'd0, 16'h7FFF, 16'h7FFF);
        cycle(0, 1, 2'd0, 4'd0, 16'h8000, 16'h8000);
        check48("R4", acc_o, m_acc);
    endtask

    task automatic t_two;
        cycle(1, 0, 2'd1, 4'd0, 0, 0);
        check2("R5", mode_o, 2'd1);
        cycle(0, 1, 2'd1, 4'd0, 16'h85_03, 16'h7F_FB);
        check48("R5", acc_o, m_acc);
        cycle(0, 1, 2'd1, 4'd0, 16'h12_F0, 16'hEE_10);
        check48("R5", acc_o, m_acc);
    endtask

    task automatic t_four;
        cycle(1, 0, 2'd2, 4'd0, 0, 0);
        check2("R6", mode_o, 2'd2);
        cycle(0, 1, 2'd2, 4'd0, 16'h7_8_3_F, 16'h9_2_5_7);
        check48("R6", acc_o, m_acc);
        cycle(0, 1, 2'd2, 4'd0, 16'hA_1_C_6, 16'h3_D_E_9);
        check48("R6", acc_o, m_acc);
    endtask

    task automatic t_round;
        cycle(1, 0, 2'd0, 4'd0, 0, 0);
        cycle(0, 1, 2'd0, 4'd4, 16'd24, 16'd16);
        check48("R2", acc_o, 48'd512);
        cycle(0, 1, 2'd0, 4'd4, 16'hFFE8, 16'd16);
        check48("R2", acc_o, 48'd256);
        cycle(1, 0, 2'd1, 4'd0, 0, 0);
        cycle(0, 1, 2'd1, 4'd15, 16'h0080, 16'h0080);
        check48("R2 clamp", acc_o, 48'd16384);
        cycle(0, 1, 2'd1, 4'd3, 16'h2D_C5, 16'hE3_16);
        check48("R2", acc_o, m_acc);
    endtask

    task automatic t_sat;
        cycle(1, 0, 2'd2, 4'd0, 0, 0);
        cycle(0, 1, 2'd2, 4'd2, 16'h0007, 16'h0007);
        check48("R3", acc_o, 48'd16);
        cycle(1, 0, 2'd0, 4'd0, 0, 0);
        cycle(0, 1, 2'd0, 4'd3, 16'h7FFE, 16'h0001);
        check48("R3", acc_o, m_acc);
    endtask

    task automatic t_wrap;
        cycle(1, 0, 2'd2, 4'd0, 0, 0);
        for (int i = 0; i < 32; i++) cycle(0, 1, 2'd2, 4'd0, 16'h0088, 16'h0088);
        check48("R7", acc_o, 48'h0000_0080_0800);
        cycle(0, 1, 2'd2, 4'd0, 16'h0001, 16'h0001);
        check48("R7", acc_o, 48'h0000_0080_0801);
        check48("R7", acc_o, m_acc);
    endtask

    task automatic t_mode_ignore;
        cycle(1, 0, 2'd1, 4'd0, 0, 0);
        cycle(0, 1, 2'd0, 4'd0, 16'h0101, 16'h0101);
        check48("R8", acc_o, 48'h0000_0100_0001);
        check2("R8", mode_o, 2'd1);
        cycle(1, 1, 2'd3, 4'd0, 16'h1234, 16'h1234);
        check2("R8", mode_o, 2'd0);
        check48("R8 R9", acc_o, '0);
    endtask

    task automatic t_hold;
        cycle(0, 1, 2'd0, 4'd0, 16'd5, 16'd7);
        cycle(0, 0, 2'd0, 4'd0, 16'd9, 16'd9);
        check48("R9", acc_o, 48'd35);
        cycle(0, 0, 2'd2, 4'd0, 16'h1111, 16'h2222);
        check48("R9", acc_o, 48'd35);
    endtask

    initial begin
        #(8 * 100000);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run did not complete");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (2) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_full();
        t_two();
        t_four();
        t_round();
        t_sat();
        t_wrap();
        t_mode_ignore();
        t_hold();
        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule